// File: doc/BRIEF.md
# Four-Output Shared-Period Pulse-Width Modulator

This block produces four pulse-width modulated signals that share a single period. Each signal comes out as a true pin and a complementary pin. Everything runs on one system clock. Two counters advance on tick-enable pulses, and each counter has its own tick source. The width counter counts the high time. The period counter closes each cycle. Each source is chosen by a 4-bit code from a bank of sixteen single-cycle tick inputs, so the high time and the cycle length can use different time bases.

Software sets the block up through a plain write strobe with an address and data. It can read any register back through a separate combinational read address. A 16-bit period value caps the width count. Each output has a 16-bit width value. The block copies the width values into working copies at the moment a period starts, so a write never produces a partial pulse.

Top module: `pwm_quad`

## Requirements
- R1: After reset all configuration registers read 0, every true output is low and every complementary output is high.
- R2: Register address 0 bit 0 is the run bit. While it is 0, the counters are held at zero, true outputs are low and complementary outputs are high. Once it is 1, the first period begins on the first width tick.
- R3: A select code n (0 to 15) takes its ticks from `tick_in[n]`. Code 1 is reserved and yields no ticks, so a counter on code 1 holds its count and the outputs hold as well.
- R4: Ticks are counted from a period's start. A period ends, and the next one starts in that same cycle, on the first period tick at which the width-tick count has reached PERIOD+1. When both selects are equal, a period is exactly PERIOD+1 ticks long.
- R5: The true output x is high for the first W width ticks of a period, where W is output x's sampled width. Each complementary output is always the inverse of its true output.
- R6: A width of 0 keeps the true output low for the whole period. A width of PERIOD+1 or more keeps it high until the period ends. With PERIOD = 65535, equal selects and width 65535, the true output still goes low for one tick in every period.
- R7: Width values are sampled only when a period starts. A write made mid-period does not change the outputs before the next period starts.
- R8: Register map. Address 0 holds the run bit in bit 0. Address 1 holds the width select in bits 3:0 and the period select in bits 7:4. Address 2 holds PERIOD. Address 4+x holds the width of output x. A write to address 3 changes nothing. Reads return the written values, unused bits and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| tick_in | input | 16 | Tick-enable pulses, one per select code |
| pwm_hi | output | 4 | True outputs |
| pwm_lo | output | 4 | Complementary outputs |

## Verification
The properties assume that tick inputs are synchronous single-cycle enables. They also assume that PERIOD is rewritten only while the run bit is clear. A shorter PERIOD written mid-period could leave the count above its bound, or let an output rise without a period start. The stimulus follows this rule: it clears the run bit, writes PERIOD, then sets the run bit again. Width values and clock selects, by contrast, are changed freely while the generator is running.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NOUT = 4,
  parameter int DW   = 16,
  parameter int SELW = 4,
  parameter int AW   = $clog2(NOUT + 4)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  input  logic [(1<<SELW)-1:0]   tick_in,
  output logic [NOUT-1:0]        pwm_hi,
  output logic [NOUT-1:0]        pwm_lo
);
  localparam int CW = DW + 1;
  localparam logic [SELW-1:0] SEL_NONE = SELW'(1);
  localparam int A_CTRL = 0;
  localparam int A_SEL  = 1;
  localparam int A_PER  = 2;
  localparam int A_WID0 = 4;

  logic            en_q, act_q;
  logic [SELW-1:0] wsel_q, psel_q;
  logic [DW-1:0]   per_q;
  logic [CW-1:0]   cnt_q, cnt_nx, per_p1;
  logic [NOUT*DW-1:0] wid_flat;
  logic            wtick, ptick, start;

  assign wtick  = (wsel_q != SEL_NONE) && tick_in[wsel_q];
  assign ptick  = (psel_q != SEL_NONE) && tick_in[psel_q];
  assign per_p1 = {1'b0, per_q} + CW'(1);
  assign cnt_nx = (wtick && cnt_q < per_p1) ? cnt_q + CW'(1) : cnt_q;
  assign start  = en_q && (act_q ? (ptick && cnt_nx >= per_p1) : wtick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wsel_q <= '0;
      psel_q <= '0;
      per_q  <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) == A_CTRL) en_q <= wr_data[0];
      if (int'(wr_addr) == A_SEL) begin
        wsel_q <= wr_data[SELW-1:0];
        psel_q <= wr_data[2*SELW-1:SELW];
      end
      if (int'(wr_addr) == A_PER) per_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_q) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    logic [DW-1:0] wid_r, wl_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wid_r <= '0;
        wl_r  <= '0;
      end else begin
        if (wr_en && int'(wr_addr) == A_WID0 + i) wid_r <= wr_data;
        if (start) wl_r <= wid_r;
      end
    end

    assign wid_flat[i*DW +: DW] = wid_r;
    assign pwm_hi[i] = act_q && (({1'b0, wl_r} > cnt_q) || ({1'b0, wl_r} >= per_p1));
    assign pwm_lo[i] = ~pwm_hi[i];
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == A_CTRL)
      rd_data[0] = en_q;
    else if (int'(rd_addr) == A_SEL)
      rd_data[2*SELW-1:0] = {psel_q, wsel_q};
    else if (int'(rd_addr) == A_PER)
      rd_data = per_q;
    else if (int'(rd_addr) >= A_WID0 && int'(rd_addr) < A_WID0 + NOUT)
      rd_data = wid_flat[(int'(rd_addr) - A_WID0)*DW +: DW];
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NOUT = 4,
  parameter int DW   = 16,
  parameter int SELW = 4,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_q,
  input logic            act_q,
  input logic            wtick,
  input logic            ptick,
  input logic            start,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [SELW-1:0] wsel_q,
  input logic [SELW-1:0] psel_q,
  input logic [DW-1:0]   per_q,
  input logic [DW:0]     cnt_q,
  input logic [NOUT-1:0] pwm_hi
);
  logic ctl_wr;
  assign ctl_wr = wr_en && (wr_addr == AW'(0) || wr_addr == AW'(2));

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> pwm_hi == '0); // R2

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && act_q && wsel_q == SELW'(1) && psel_q == SELW'(1) && !ctl_wr)
      |=> ($stable(cnt_q) && $stable(pwm_hi))); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= {1'b0, per_q} + (DW+1)'(1)); // R4

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pwm_hi & ~$past(pwm_hi))) |-> $past(start)); // R5

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && act_q && !wtick && !ptick && !ctl_wr) |=> $stable(pwm_hi)); // R7
endmodule

bind pwm_quad pwm_quad_chk #(.NOUT(NOUT), .DW(DW), .SELW(SELW), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .act_q(act_q), .wtick(wtick),
  .ptick(ptick), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
  .wsel_q(wsel_q), .psel_q(psel_q), .per_q(per_q), .cnt_q(cnt_q),
  .pwm_hi(pwm_hi)
);

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
  localparam int NOUT = 4;
  localparam int DW   = 16;
  localparam int AW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [15:0]   tick_in = 16'h0;
  logic [31:0]   lfsr = 32'h1;
  wire  [DW-1:0] rd_data;
  wire  [NOUT-1:0] pwm_hi, pwm_lo;

  pwm_quad i_pwm_quad (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_in(tick_in), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R5";
  bit cmp_on = 1'b0;
  bit cnt_low = 1'b0;
  int low_seen = 0;

  int m_en, m_ws, m_ps, m_per, m_act, m_cnt, m_nx;
  int m_w[NOUT];
  int m_wl[NOUT];
  bit m_wt, m_pt;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    tick_in = {lfsr[15:1] & lfsr[30:16], 1'b1};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ws = 0; m_ps = 0; m_per = 0; m_act = 0; m_cnt = 0;
      for (int k = 0; k < NOUT; k++) begin m_w[k] = 0; m_wl[k] = 0; end
    end else begin
      m_wt = (m_ws != 1) && tick_in[m_ws];
      m_pt = (m_ps != 1) && tick_in[m_ps];
      if (m_en == 0) begin
        m_act = 0; m_cnt = 0;
      end else if (m_act == 0) begin
        if (m_wt) begin
          m_act = 1; m_cnt = 0;
          for (int k = 0; k < NOUT; k++) m_wl[k] = m_w[k];
        end
      end else begin
        m_nx = (m_wt && m_cnt < m_per + 1) ? m_cnt + 1 : m_cnt;
        if (m_pt && m_nx >= m_per + 1) begin
          m_cnt = 0;
          for (int k = 0; k < NOUT; k++) m_wl[k] = m_w[k];
        end else m_cnt = m_nx;
      end
      if (wr_en) begin
        case (int'(wr_addr))
          0: m_en = int'(wr_data[0]);
          1: begin m_ws = int'(wr_data[3:0]); m_ps = int'(wr_data[7:4]); end
          2: m_per = int'(wr_data);
          3: ;
          default: m_w[int'(wr_addr) - 4] = int'(wr_data);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int k = 0; k < NOUT; k++) begin
        bit e;
        e = (m_act != 0) && (m_cnt < m_wl[k] || m_wl[k] >= m_per + 1);
        chk({pwm_hi[k], pwm_lo[k]} == {e, ~e}, cur_req, $sformatf("out%0d hi/lo", k),
            int'({pwm_hi[k], pwm_lo[k]}), int'({e, ~e}));
      end
      if (cnt_low && !pwm_hi[0]) low_seen++;
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d[DW-1:0];
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rdchk(int a, int e, string req);
    rd_addr = a[AW-1:0];
    #1;
    chk(rd_data == e[DW-1:0], req, $sformatf("read addr %0d", a), int'(rd_data), e);
  endtask

  task automatic rd_all(string req);
    rdchk(0, m_en, req);
    rdchk(1, m_ws | (m_ps << 4), req);
    rdchk(2, m_per, req);
    rdchk(3, 0, req);
    for (int k = 0; k < NOUT; k++) rdchk(4 + k, m_w[k], req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", 1, 0);
    finish_up();
  end

  initial begin
    logic [NOUT-1:0] held;
    repeat (3) @(posedge clk);
    #5;
    chk(pwm_hi == '0, "R1", "reset true outputs", int'(pwm_hi), 0);
    chk(pwm_lo == '1, "R1", "reset complement outputs", int'(pwm_lo), 15);
    rd_all("R1");
    @(posedge clk); #2;
    rst_n = 1'b1;
    cmp_on = 1'b1;

    cur_req = "R8";
    wr(4, 0); wr(5, 2); wr(6, 5); wr(7, 9);
    wr(2, 6); wr(1, 16'h00);
    rd_all("R8");
    cur_req = "R2";
    wr(0, 1);
    cur_req = "R4";
    repeat (200) @(posedge clk);

    cur_req = "R6";
    wr(4, 7); wr(5, 100); wr(6, 0);
    repeat (100) @(posedge clk);

    wr(0, 0); wr(2, 20); wr(1, 16'h52); wr(0, 1);
    cur_req = "R7";
    for (int j = 0; j < 40; j++) begin
      wr(4 + (j % 4), int'(lfsr[4:0]));
      repeat (3) @(posedge clk);
    end
    repeat (300) @(posedge clk);

    wr(3, 16'hffff);
    rd_all("R8");

    cur_req = "R3";
    wr(1, 16'h11);
    @(negedge clk);
    held = pwm_hi;
    repeat (50) @(posedge clk);
    #5;
    chk(pwm_hi == held, "R3", "reserved selects hold outputs", int'(pwm_hi), int'(held));
    wr(1, 16'h21);
    repeat (200) @(posedge clk);

    cur_req = "R4";
    wr(0, 0); wr(2, 0); wr(1, 0);
    wr(4, 0); wr(5, 1); wr(6, 1); wr(7, 0);
    wr(0, 1);
    repeat (50) @(posedge clk);

    cur_req = "R2";
    wr(0, 0);
    repeat (2) @(posedge clk);
    #5;
    chk(pwm_hi == '0, "R2", "disabled true outputs", int'(pwm_hi), 0);
    chk(pwm_lo == '1, "R2", "disabled complement outputs", int'(pwm_lo), 15);

    cur_req = "R6";
    for (int k = 0; k < NOUT; k++) wr(4 + k, 16'hffff);
    wr(2, 16'hffff);
    wr(0, 1);
    repeat (5) @(posedge clk);
    cnt_low = 1'b1;
    repeat (65560) @(posedge clk);
    cnt_low = 1'b0;
    chk(low_seen > 0, "R6", "max period never reaches full duty", low_seen, 1);

    finish_up();
  end
endmodule